// File: doc/BRIEF.md
# Signal Intercept Cell Bank

This block places a row of identical intercept cells on signal paths between two parts of a base processor. Each cell connects a source to its original destination and also connects to an optional monitor layer stacked above the base die. The monitor layer programs a mode for each cell. That mode decides whether the cell leaves the path alone, copies the signal to the monitor, diverts it to the monitor, replaces it with a monitor value, or blocks it.

The monitor layer programs the modes through a one-cycle register write that carries a cell index and a 3-bit mode code. The path through each cell is purely combinational, and only the configuration is held in flops. A presence input from the monitor layer gates the whole bank. While that input is low, every cell acts as a plain wire, so the base design keeps working when no monitor is stacked on it.

Blocked paths drive zero data, and a per-cell destination valid flag is held low so that the receiver can tell a blocked path from a real zero. The observation outputs stay at zero unless a cell is copying or diverting, so the monitor port never exposes data the monitor has not asked for.

Top module: `sig_intercept_bank`

## Requirements
- R1: After reset, every cell is in pass mode.
- R2: Pass mode (code 0) drives the source value to the destination with destination valid high. It drives observation data and observation valid to zero.
- R3: Tap mode (code 1) drives the source value to the destination with destination valid high. It also drives the same value on the observation output with observation valid high.
- R4: Reroute mode (code 2) drives the source value on the observation output with observation valid high. The destination gets zero data with destination valid low.
- R5: Override mode (code 3) drives the cell's override input to the destination with destination valid high. Observation data and observation valid are zero.
- R6: Disable mode (code 4) drives zero on destination data, destination valid, observation data and observation valid.
- R7: Mode codes 5, 6 and 7 behave exactly like pass mode.
- R8: While layer_present_i is low, every cell behaves as in pass mode, whatever mode it holds.
- R9: A write with cfg_we_i high sets the mode of cell cfg_idx_i, and the new mode takes effect from the first clock edge after the write. Other cells keep their modes, and cycles with cfg_we_i low change no mode.
- R10: The data path is combinational: a change on source or override data shows on the outputs in the same cycle, with no clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock for the mode registers |
| rst_ni | input | 1 | Asynchronous reset, active low |
| layer_present_i | input | 1 | High when the monitor layer is attached |
| cfg_we_i | input | 1 | Mode write strobe |
| cfg_idx_i | input | IDX_W | Cell index for the write |
| cfg_mode_i | input | 3 | Mode code for the write |
| src_data_i | input | N_CELLS*DATA_W | Source value for each cell |
| ovr_data_i | input | N_CELLS*DATA_W | Value for each cell from the monitor, used in override |
| dst_data_o | output | N_CELLS*DATA_W | Value for each original destination |
| dst_valid_o | output | N_CELLS | Destination data is real, one bit per cell |
| obs_data_o | output | N_CELLS*DATA_W | Observation value for each cell, to the monitor |
| obs_valid_o | output | N_CELLS | Observation data is real, one bit per cell |

## Verification
The bench sweeps all eight mode codes across all four cells with several data patterns. Each pattern runs with the layer present and with it absent, so every cell is compared against an arithmetic model. If the presence gating were missing, a monitor-less chip would block or divert traffic. If codes 5 to 7 fell through to another decode, some cells would silently block data. If observation were not gated, pass mode would leak source data to the monitor, and an override that forwarded the source would let the original value through. The timing checks catch a mode that applies before the clock edge or never applies, a write that reaches the wrong cell, and a data path with a hidden register.

// File: rtl/intercept_pkg.sv
package intercept_pkg;

  localparam int unsigned MODE_W = 3;

  typedef enum logic [MODE_W-1:0] {
    MODE_PASS     = 3'd0,
    MODE_TAP      = 3'd1,
    MODE_REROUTE  = 3'd2,
    MODE_OVERRIDE = 3'd3,
    MODE_DISABLE  = 3'd4
  } icpt_mode_e;

  // per-mode path steering
  typedef struct packed {
    logic fwd_src;
    logic fwd_ovr;
    logic dst_vld;
    logic obs_en;
  } path_ctrl_t;

  // unused codes collapse to pass
  function automatic icpt_mode_e decode_mode(input logic [MODE_W-1:0] raw);
    case (raw)
      3'd1:    return MODE_TAP;
      3'd2:    return MODE_REROUTE;
      3'd3:    return MODE_OVERRIDE;
      3'd4:    return MODE_DISABLE;
      default: return MODE_PASS;
    endcase
  endfunction

  function automatic path_ctrl_t mode_ctrl(input icpt_mode_e m);
    path_ctrl_t c;
    c = '0;
    case (m)
      MODE_TAP:      begin c.fwd_src = 1'b1; c.dst_vld = 1'b1; c.obs_en = 1'b1; end
      MODE_REROUTE:  begin c.obs_en  = 1'b1; end
      MODE_OVERRIDE: begin c.fwd_ovr = 1'b1; c.dst_vld = 1'b1; end
      MODE_DISABLE:  begin c = '0; end
      default:       begin c.fwd_src = 1'b1; c.dst_vld = 1'b1; end
    endcase
    return c;
  endfunction

endpackage

// File: rtl/intercept_cfg_regs.sv
module intercept_cfg_regs
  import intercept_pkg::*;
#(
  parameter int unsigned N_CELLS = 4,
  parameter int unsigned IDX_W   = (N_CELLS > 1) ? $clog2(N_CELLS) : 1
) (
  input  logic                              clk_i,
  input  logic                              rst_ni,
  input  logic                              we_i,
  input  logic [IDX_W-1:0]                  idx_i,
  input  logic [MODE_W-1:0]                 mode_i,
  output logic [N_CELLS-1:0][MODE_W-1:0]    mode_o
);

  icpt_mode_e wr_mode;
  assign wr_mode = decode_mode(mode_i);

  for (genvar g = 0; g < N_CELLS; g++) begin : g_reg
    logic sel;
    assign sel = we_i && (idx_i == IDX_W'(g));

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)  mode_o[g] <= MODE_PASS;
      else if (sel) mode_o[g] <= wr_mode;
    end
  end

endmodule

// File: rtl/intercept_cell.sv
module intercept_cell
  import intercept_pkg::*;
#(
  parameter int unsigned DATA_W = 8
) (
  input  logic              present_i,
  input  logic [MODE_W-1:0] mode_i,
  input  logic [DATA_W-1:0] src_i,
  input  logic [DATA_W-1:0] ovr_i,
  output logic [DATA_W-1:0] dst_o,
  output logic              dst_valid_o,
  output logic [DATA_W-1:0] obs_o,
  output logic              obs_valid_o
);

  icpt_mode_e eff_mode;
  path_ctrl_t ctrl;

  // absent monitor forces a plain wire
  assign eff_mode = present_i ? decode_mode(mode_i) : MODE_PASS;
  assign ctrl     = mode_ctrl(eff_mode);

  always_comb begin
    dst_o = '0;
    if (ctrl.fwd_src)      dst_o = src_i;
    else if (ctrl.fwd_ovr) dst_o = ovr_i;
  end

  assign dst_valid_o = ctrl.dst_vld;
  assign obs_o       = ctrl.obs_en ? src_i : '0;
  assign obs_valid_o = ctrl.obs_en;

endmodule

// File: rtl/sig_intercept_bank.sv
module sig_intercept_bank
  import intercept_pkg::*;
#(
  parameter int unsigned N_CELLS = 4,
  parameter int unsigned DATA_W  = 8,
  localparam int unsigned IDX_W  = (N_CELLS > 1) ? $clog2(N_CELLS) : 1
) (
  input  logic                           clk_i,
  input  logic                           rst_ni,
  input  logic                           layer_present_i,
  input  logic                           cfg_we_i,
  input  logic [IDX_W-1:0]               cfg_idx_i,
  input  logic [2:0]                     cfg_mode_i,
  input  logic [N_CELLS-1:0][DATA_W-1:0] src_data_i,
  input  logic [N_CELLS-1:0][DATA_W-1:0] ovr_data_i,
  output logic [N_CELLS-1:0][DATA_W-1:0] dst_data_o,
  output logic [N_CELLS-1:0]             dst_valid_o,
  output logic [N_CELLS-1:0][DATA_W-1:0] obs_data_o,
  output logic [N_CELLS-1:0]             obs_valid_o
);

  logic [N_CELLS-1:0][MODE_W-1:0] cell_mode;

  intercept_cfg_regs #(
    .N_CELLS (N_CELLS),
    .IDX_W   (IDX_W)
  ) u_cfg (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .we_i   (cfg_we_i),
    .idx_i  (cfg_idx_i),
    .mode_i (cfg_mode_i),
    .mode_o (cell_mode)
  );

  for (genvar g = 0; g < N_CELLS; g++) begin : g_cell
    intercept_cell #(
      .DATA_W (DATA_W)
    ) u_cell (
      .present_i   (layer_present_i),
      .mode_i      (cell_mode[g]),
      .src_i       (src_data_i[g]),
      .ovr_i       (ovr_data_i[g]),
      .dst_o       (dst_data_o[g]),
      .dst_valid_o (dst_valid_o[g]),
      .obs_o       (obs_data_o[g]),
      .obs_valid_o (obs_valid_o[g])
    );
  end

endmodule

// File: rtl/intercept_bank_chk.sv
module intercept_bank_chk #(
  parameter int unsigned N_CELLS = 4,
  parameter int unsigned DATA_W  = 8,
  parameter int unsigned IDX_W   = 2
) (
  input logic                           clk_i,
  input logic                           rst_ni,
  input logic                           layer_present_i,
  input logic                           cfg_we_i,
  input logic [IDX_W-1:0]               cfg_idx_i,
  input logic [2:0]                     cfg_mode_i,
  input logic [N_CELLS-1:0][DATA_W-1:0] src_data_i,
  input logic [N_CELLS-1:0][DATA_W-1:0] ovr_data_i,
  input logic [N_CELLS-1:0][DATA_W-1:0] dst_data_o,
  input logic [N_CELLS-1:0]             dst_valid_o,
  input logic [N_CELLS-1:0][DATA_W-1:0] obs_data_o,
  input logic [N_CELLS-1:0]             obs_valid_o
);

  for (genvar g = 0; g < N_CELLS; g++) begin : g_chk
    // R8
    absent_wire_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !layer_present_i |-> (dst_data_o[g] == src_data_i[g]) && dst_valid_o[g]
                           && !obs_valid_o[g] && (obs_data_o[g] == '0));

    // R2
    obs_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !obs_valid_o[g] |-> (obs_data_o[g] == '0));

    // R3
    obs_copy_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      obs_valid_o[g] |-> (obs_data_o[g] == src_data_i[g]));

    // R4
    blocked_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !dst_valid_o[g] |-> (dst_data_o[g] == '0));

    // R5
    replace_src_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (dst_valid_o[g] && (dst_data_o[g] != src_data_i[g])) |->
        ((dst_data_o[g] == ovr_data_i[g]) && !obs_valid_o[g]));

    // R9
    disable_write_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (cfg_we_i && (cfg_idx_i == IDX_W'(g)) && (cfg_mode_i == 3'd4)) |=>
        (!layer_present_i || (!dst_valid_o[g] && !obs_valid_o[g])));
  end

endmodule

bind sig_intercept_bank intercept_bank_chk #(
  .N_CELLS (N_CELLS),
  .DATA_W  (DATA_W),
  .IDX_W   (IDX_W)
) u_chk (
  .clk_i           (clk_i),
  .rst_ni          (rst_ni),
  .layer_present_i (layer_present_i),
  .cfg_we_i        (cfg_we_i),
  .cfg_idx_i       (cfg_idx_i),
  .cfg_mode_i      (cfg_mode_i),
  .src_data_i      (src_data_i),
  .ovr_data_i      (ovr_data_i),
  .dst_data_o      (dst_data_o),
  .dst_valid_o     (dst_valid_o),
  .obs_data_o      (obs_data_o),
  .obs_valid_o     (obs_valid_o)
);

// File: tb/sig_intercept_bank_tb.sv
`timescale 1ns/1ps
module sig_intercept_bank_tb;

  localparam int N = 4;
  localparam int W = 8;

  logic                 clk = 1'b0;
  logic                 rst_n = 1'b0;
  logic                 present = 1'b1;
  logic                 we = 1'b0;
  logic [1:0]           idx = '0;
  logic [2:0]           mode = '0;
  logic [N-1:0][W-1:0]  src = '0;
  logic [N-1:0][W-1:0]  ovr = '0;
  logic [N-1:0][W-1:0]  dst;
  logic [N-1:0]         dv;
  logic [N-1:0][W-1:0]  obs;
  logic [N-1:0]         ov;

  int checks = 0;
  int errors = 0;
  int model [N];
  bit done = 0;

  always #10 clk = ~clk;

  sig_intercept_bank #(.N_CELLS(N), .DATA_W(W)) u_dut (
    .clk_i(clk), .rst_ni(rst_n), .layer_present_i(present),
    .cfg_we_i(we), .cfg_idx_i(idx), .cfg_mode_i(mode),
    .src_data_i(src), .ovr_data_i(ovr),
    .dst_data_o(dst), .dst_valid_o(dv), .obs_data_o(obs), .obs_valid_o(ov)
  );

  // {dst, dst_valid, obs, obs_valid}
  function automatic logic [2*W+1:0] expect_cell(int m, bit pres, logic [W-1:0] s, logic [W-1:0] o);
    if (!pres) return {s, 1'b1, 8'h00, 1'b0};
    case (m)
      1:       return {s, 1'b1, s, 1'b1};
      2:       return {8'h00, 1'b0, s, 1'b1};
      3:       return {o, 1'b1, 8'h00, 1'b0};
      4:       return {8'h00, 1'b0, 8'h00, 1'b0};
      default: return {s, 1'b1, 8'h00, 1'b0};
    endcase
  endfunction

  function automatic string mode_tag(int m, bit pres);
    if (!pres) return "R8";
    case (m)
      0: return "R2";
      1: return "R3";
      2: return "R4";
      3: return "R5";
      4: return "R6";
      default: return "R7";
    endcase
  endfunction

  task automatic check_cell(int c, int m, string tag);
    logic [2*W+1:0] exp_v, act_v;
    exp_v = expect_cell(m, present, src[c], ovr[c]);
    act_v = {dst[c], dv[c], obs[c], ov[c]};
    checks++;
    if (act_v !== exp_v) begin
      errors++;
      $display("FAIL %s cell %0d mode %0d: actual=%h expected=%h", tag, c, m, act_v, exp_v);
    end
  endtask

  task automatic write_mode(int c, int m);
    @(negedge clk);
    we = 1'b1; idx = 2'(c); mode = 3'(m);
    @(negedge clk);
    we = 1'b0;
    model[c] = m;
  endtask

  task automatic load_pattern(int p);
    for (int c = 0; c < N; c++) begin
      src[c] = 8'((p * 37 + c * 11 + 5) & 255);
      ovr[c] = src[c] ^ (8'h5A | 8'(c));
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  endtask

  initial begin
    #(20 * 20000);
    errors++; checks++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    finish_run();
  end

  initial begin
    for (int c = 0; c < N; c++) model[c] = 0;
    load_pattern(3);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk); #1;
    // R1: reset leaves every cell in pass
    for (int c = 0; c < N; c++) check_cell(c, 0, "R1");

    // Sweep every code over every cell, layer present and absent
    for (int m = 0; m < 8; m++) begin
      for (int c = 0; c < N; c++) write_mode(c, (m + c) % 8);
      for (int p = 0; p < 4; p++) begin
        for (int pr = 0; pr < 2; pr++) begin
          @(negedge clk);
          present = (pr == 0);
          load_pattern(p * 5 + m);
          #1;
          for (int c = 0; c < N; c++) check_cell(c, model[c], mode_tag(model[c], present));
        end
      end
    end
    present = 1'b1;

    // R9: a new mode waits for the clock edge and touches one cell only
    for (int c = 0; c < N; c++) write_mode(c, 1);
    @(negedge clk);
    we = 1'b1; idx = 2'd2; mode = 3'd4;
    #1;
    check_cell(2, 1, "R9");
    @(posedge clk); #1;
    we = 1'b0;
    model[2] = 4;
    check_cell(2, 4, "R9");
    check_cell(1, 1, "R9");
    check_cell(3, 1, "R9");
    // R9: strobe low leaves modes alone
    idx = 2'd2; mode = 3'd3;
    repeat (2) @(negedge clk);
    #1;
    check_cell(2, 4, "R9");
    idx = 2'd0; mode = 3'd2;
    repeat (2) @(negedge clk);
    #1;
    check_cell(0, 1, "R9");

    // R10: data changes show without a clock edge
    write_mode(0, 3);
    write_mode(1, 1);
    @(negedge clk);
    src[0] = 8'h11; ovr[0] = 8'hC3; src[1] = 8'h22;
    #1;
    check_cell(0, 3, "R10");
    check_cell(1, 1, "R10");
    #3;
    ovr[0] = 8'h3C; src[1] = 8'h99;
    #1;
    check_cell(0, 3, "R10");
    check_cell(1, 1, "R10");

    // R8: dropping presence mid-cycle reverts at once
    present = 1'b0;
    #1;
    for (int c = 0; c < N; c++) check_cell(c, model[c], "R8");
    present = 1'b1;

    repeat (2) @(negedge clk);
    finish_run();
  end

endmodule